// File: doc/BRIEF.md
# Password-Gated Command Sequencer

This block is the byte-level control core of a password-protected serial memory slave. A two-wire front end hands it received bytes together with start and stop event strobes. For every byte it returns one acknowledge decision, one cycle later. The block parses the command byte and the eight password bytes. It then requires a separate polling byte before it accepts a two-byte address. After that it either streams read data from one of two on-chip arrays or takes sector write data into them.

Every password attempt is followed by a busy interval whose length is a parameter in clock cycles. This interval stands in for a nonvolatile write cycle. During it a polling byte is refused, so the host cannot tell a wrong password from a device that is still busy. Five 64-bit password slots guard read and write of each array plus a reset slot. A slot is changed by entering the new value twice, and the change is accepted only when the two copies agree. A read byte is fetched when the front end raises `rd_req` while the block is streaming, and the byte appears on `rd_data` with `rd_vld` one cycle later.

Top module: `pwgate_seq`

## Requirements
- R1: The first byte after a start is decoded as a command. 0x80 reads array 0, 0x90 reads array 1, 0xA0 writes array 0, 0xB0 writes array 1, 0x88/0x98/0xA8/0xB8/0xC8 change the read0/read1/write0/write1/reset password, 0xE0 resets all passwords, 0xE8 is reset-device and 0xF0 is the poll. A valid code is acknowledged (ack=1). Any other code gets ack=0 and the block returns to standby.
- R2: The eight bytes after a non-poll command form the password, first byte most significant, and each of them is acknowledged. The last one always starts the busy interval, and a poll during that interval gets ack=0.
- R3: A poll (0xF0) after the busy interval is acknowledged only if the last password matched the slot chosen by the command. A refused poll ends the session, so later bytes without a start get ack=0.
- R4: After an acknowledged poll, a high address byte and then a low address byte are accepted and acknowledged. Array 0 uses the low A0_AW address bits and array 1 uses the low A1_AW bits.
- R5: A sector write accepts up to SECTOR (32) data bytes at consecutive addresses, each acknowledged. Further bytes get ack=0 and are not stored. A stop after at least one data byte starts the busy interval.
- R6: Each read request returns the byte at the current address and then advances it. The address wraps from 2^A0_AW-1 (0x7FF by default) to 0 in array 0 and from 0x1F to 0 in array 1.
- R7: A repeated start while reading, followed by one byte, replaces only the low 8 address bits in array 0 and the whole address in array 1. Reading then resumes without a new password.
- R8: A password change takes the old password, a poll, two filler bytes and then the new value twice. If the copies differ, the block returns to standby with no busy interval, a poll is acknowledged at once and the old value stays valid. If they match, the slot is rewritten and a poll gets ack=0 until the busy interval ends.
- R9: After reset all password slots are zero. 0xE0 with the reset password, followed by an acknowledged poll, sets all slots to zero and starts a busy interval.
- R10: During the busy interval any command byte gets ack=0, and start or stop events do not end the pending password session.
- R11: When not busy, a stop (or a non-reading start) during password, address or data input abandons the session. A following byte without a start gets ack=0.
- R12: After reset ack_vld and rd_vld are low, and a byte received before any start gets ack=0. Exactly one acknowledge pulse follows each received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_ev | input | 1 | Start condition seen by front end (one-cycle pulse) |
| stop_ev | input | 1 | Stop condition seen by front end (one-cycle pulse) |
| byte_vld | input | 1 | A received byte is on byte_in |
| byte_in | input | 8 | Received byte |
| rd_req | input | 1 | Front end requests the next read byte |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| rd_vld | output | 1 | Read byte valid on rd_data |
| rd_data | output | 8 | Read byte |

## Verification
A corrupted session flag or password-match flag shows up at the very next poll byte, as an acknowledge where a refusal was due or the reverse, two cycles after the start. A wrong address register or a wrong wrap mask surfaces on the first read that follows, because every written pattern is read back across the array tops. A busy counter that runs too short or too long flips the poll answer issued right after a password or a write. A broken compare of the duplicate new password is caught both by the immediate poll and by the next open with the old or the new value.

// File: rtl/pwgate_pkg.sv
package pwgate_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_PWD,
        S_HOLD,
        S_ADRH,
        S_ADRL,
        S_WDAT,
        S_RDAT,
        S_RADR,
        S_NEWPW
    } st_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_RD,
        K_WR,
        K_CHG,
        K_RSTPW,
        K_RSTDEV,
        K_POLL
    } kind_e;

    localparam int SLOT_W = 3;
    localparam int NUM_SLOTS = 5;

    function automatic kind_e cmd_kind(input logic [7:0] c);
        kind_e k;
        case (c)
            8'h80, 8'h90: k = K_RD;
            8'hA0, 8'hB0: k = K_WR;
            8'h88, 8'h98, 8'hA8, 8'hB8, 8'hC8: k = K_CHG;
            8'hE0: k = K_RSTPW;
            8'hE8: k = K_RSTDEV;
            8'hF0: k = K_POLL;
            default: k = K_NONE;
        endcase
        return k;
    endfunction

    // slot 0: read0, 1: read1, 2: write0, 3: write1, 4: reset
    function automatic logic [SLOT_W-1:0] cmd_slot(input logic [7:0] c);
        logic [SLOT_W-1:0] s;
        case (c)
            8'h80, 8'h88: s = 3'd0;
            8'h90, 8'h98: s = 3'd1;
            8'hA0, 8'hA8: s = 3'd2;
            8'hB0, 8'hB8: s = 3'd3;
            default:      s = 3'd4;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwgate_ram.sv
module pwgate_ram #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/pwgate_busy.sv
module pwgate_busy #(
    parameter int CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (kick) begin
            cnt_d = CW'(CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/pwgate_pwbank.sv
module pwgate_pwbank #(
    parameter int NUM   = 5,
    parameter int W     = 64,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [W-1:0]     wval,
    input  logic [SEL_W-1:0] rsel,
    output logic [W-1:0]     rval
);
    localparam int SLOTS = 1 << SEL_W;

    logic [W-1:0] slot_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (clr || i >= NUM) begin
                    slot_q[i] <= '0;
                end else if (we && wsel == SEL_W'(i)) begin
                    slot_q[i] <= wval;
                end
            end
        end
    end

    assign rval = slot_q[rsel];
endmodule

// File: rtl/pwgate_seq.sv
module pwgate_seq
    import pwgate_pkg::*;
#(
    parameter int A0_AW    = 11,
    parameter int A1_AW    = 5,
    parameter int SECTOR   = 32,
    parameter int PW_BYTES = 8,
    parameter int BUSY_CYC = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       rd_req,
    output logic       ack_vld,
    output logic       ack,
    output logic       rd_vld,
    output logic [7:0] rd_data
);
    localparam int AW   = A0_AW;
    localparam int PW_W = PW_BYTES * 8;
    localparam int WC_W = $clog2(SECTOR + 1);
    localparam int BC_W = $clog2(2 * PW_BYTES);
    localparam logic [AW-1:0] LOMASK = AW'(8'hFF);
    localparam logic [AW-1:0] A1MASK = AW'((1 << A1_AW) - 1);

    typedef struct packed {
        st_e             st;
        logic [7:0]      cmd;
        logic            sess;
        logic            pass_ok;
        logic [PW_W-1:0] pbuf;
        logic [PW_W-1:0] nbuf;
        logic            mism;
        logic [BC_W-1:0] bcnt;
        logic [AW-1:0]   addr;
        logic [WC_W-1:0] wcnt;
        logic            ack_vld;
        logic            ack;
        logic            rd_vld;
    } ctl_t;

    ctl_t d, q;

    logic              busy_w;
    logic              kick;
    logic [1:0]        ram_we;
    logic [1:0]        ram_re;
    logic              pw_we;
    logic              pw_clr;
    logic [PW_W-1:0]   pw_wval;
    logic [PW_W-1:0]   pw_rval;
    logic [SLOT_W-1:0] sess_slot;
    kind_e             in_kind;
    kind_e             sess_kind;
    logic              arr;
    logic [AW-1:0]     amask;
    logic [AW-1:0]     addr_inc;
    logic [PW_W-1:0]   pw_shift;
    logic [PW_W-1:0]   nbuf_rot;
    logic              nb_diff;
    logic [7:0]        rdq [2];

    assign in_kind   = cmd_kind(byte_in);
    assign sess_kind = cmd_kind(q.cmd);
    assign sess_slot = cmd_slot(q.cmd);
    assign arr       = q.cmd[4];
    assign amask     = arr ? A1MASK : {AW{1'b1}};
    assign addr_inc  = (q.addr + 1'b1) & amask;
    assign pw_shift  = {q.pbuf[PW_W-9:0], byte_in};
    assign nbuf_rot  = {q.nbuf[PW_W-9:0], q.nbuf[PW_W-1 -: 8]};
    assign nb_diff   = (byte_in != q.nbuf[PW_W-1 -: 8]);
    assign pw_wval   = nbuf_rot;

    always_comb begin
        d         = q;
        d.ack_vld = 1'b0;
        d.ack     = 1'b0;
        d.rd_vld  = 1'b0;
        kick      = 1'b0;
        ram_we    = '0;
        ram_re    = '0;
        pw_we     = 1'b0;
        pw_clr    = 1'b0;

        if (start_ev) begin
            if (busy_w || q.st == S_HOLD) begin
                d.st = S_CMD;
            end else if (q.st == S_RDAT || q.st == S_RADR) begin
                d.st = S_RADR;
            end else begin
                d.st   = S_CMD;
                d.sess = 1'b0;
            end
        end else if (stop_ev) begin
            if (!(busy_w || q.st == S_HOLD)) begin
                if (q.st == S_WDAT && q.wcnt != '0) begin
                    kick = 1'b1;
                end
                d.st   = S_IDLE;
                d.sess = 1'b0;
            end
        end else if (byte_vld) begin
            d.ack_vld = 1'b1;
            unique case (q.st)
                S_CMD: begin
                    if (busy_w) begin
                        d.st = q.sess ? S_HOLD : S_IDLE;
                    end else if (in_kind == K_POLL) begin
                        d.ack = q.pass_ok;
                        if (q.pass_ok && q.sess) begin
                            unique case (sess_kind)
                                K_RD, K_WR, K_CHG: begin
                                    d.st = S_ADRH;
                                end
                                K_RSTPW: begin
                                    pw_clr = 1'b1;
                                    kick   = 1'b1;
                                    d.st   = S_IDLE;
                                    d.sess = 1'b0;
                                end
                                default: begin
                                    d.st   = S_IDLE;
                                    d.sess = 1'b0;
                                end
                            endcase
                        end else begin
                            d.st   = S_IDLE;
                            d.sess = 1'b0;
                        end
                    end else if (in_kind != K_NONE) begin
                        d.ack  = 1'b1;
                        d.cmd  = byte_in;
                        d.sess = 1'b1;
                        d.bcnt = '0;
                        d.st   = S_PWD;
                    end else begin
                        d.st   = S_IDLE;
                        d.sess = 1'b0;
                    end
                end
                S_PWD: begin
                    d.ack  = 1'b1;
                    d.pbuf = pw_shift;
                    d.bcnt = q.bcnt + 1'b1;
                    if (q.bcnt == BC_W'(PW_BYTES - 1)) begin
                        d.pass_ok = (pw_shift == pw_rval);
                        kick      = 1'b1;
                        d.st      = S_HOLD;
                    end
                end
                S_HOLD: begin
                    d.st   = S_IDLE;
                    d.sess = 1'b0;
                end
                S_ADRH: begin
                    d.ack  = 1'b1;
                    d.addr = AW'({byte_in, 8'h00});
                    d.st   = S_ADRL;
                end
                S_ADRL: begin
                    d.ack  = 1'b1;
                    d.addr = ((q.addr & ~LOMASK) | AW'(byte_in)) & amask;
                    d.wcnt = '0;
                    d.bcnt = '0;
                    d.mism = 1'b0;
                    unique case (sess_kind)
                        K_RD:    d.st = S_RDAT;
                        K_WR:    d.st = S_WDAT;
                        default: d.st = S_NEWPW;
                    endcase
                end
                S_WDAT: begin
                    if (q.wcnt < WC_W'(SECTOR)) begin
                        d.ack       = 1'b1;
                        ram_we[arr] = 1'b1;
                        d.addr      = addr_inc;
                        d.wcnt      = q.wcnt + 1'b1;
                    end
                end
                S_RADR: begin
                    d.ack  = 1'b1;
                    d.addr = arr ? (AW'(byte_in) & amask)
                                 : ((q.addr & ~LOMASK) | AW'(byte_in));
                    d.st   = S_RDAT;
                end
                S_NEWPW: begin
                    d.ack  = 1'b1;
                    d.bcnt = q.bcnt + 1'b1;
                    if (q.bcnt < BC_W'(PW_BYTES)) begin
                        d.nbuf = {q.nbuf[PW_W-9:0], byte_in};
                    end else begin
                        d.nbuf = nbuf_rot;
                        d.mism = q.mism | nb_diff;
                        if (q.bcnt == BC_W'(2 * PW_BYTES - 1)) begin
                            if (!(q.mism | nb_diff)) begin
                                pw_we = 1'b1;
                                kick  = 1'b1;
                            end
                            d.st   = S_IDLE;
                            d.sess = 1'b0;
                        end
                    end
                end
                default: begin
                    d.ack = 1'b0;
                end
            endcase
        end else if (rd_req && q.st == S_RDAT) begin
            ram_re[arr] = 1'b1;
            d.addr      = addr_inc;
            d.rd_vld    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    pwgate_busy #(.CYC(BUSY_CYC)) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .kick (kick),
        .busy (busy_w)
    );

    pwgate_pwbank #(.NUM(NUM_SLOTS), .W(PW_W), .SEL_W(SLOT_W)) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (pw_clr),
        .we   (pw_we),
        .wsel (sess_slot),
        .wval (pw_wval),
        .rsel (sess_slot),
        .rval (pw_rval)
    );

    for (genvar g = 0; g < 2; g++) begin : g_arr
        localparam int GAW = (g == 0) ? A0_AW : A1_AW;
        pwgate_ram #(.AW(GAW), .DW(8)) u_ram (
            .clk  (clk),
            .we   (ram_we[g]),
            .waddr(q.addr[GAW-1:0]),
            .wdata(byte_in),
            .re   (ram_re[g]),
            .raddr(q.addr[GAW-1:0]),
            .rdata(rdq[g])
        );
    end

    // signals brought out for the bound checker
    logic            chk_in_cmd;
    logic            chk_pwd_last;
    logic            chk_sess;
    logic [WC_W-1:0] chk_wcnt;
    assign chk_in_cmd   = (q.st == S_CMD);
    assign chk_pwd_last = (q.st == S_PWD) && (q.bcnt == BC_W'(PW_BYTES - 1));
    assign chk_sess     = q.sess;
    assign chk_wcnt     = q.wcnt;

    assign ack_vld = q.ack_vld;
    assign ack     = q.ack;
    assign rd_vld  = q.rd_vld;
    assign rd_data = rdq[arr];
endmodule

// File: rtl/pwgate_chk.sv
module pwgate_chk #(
    parameter int SECTOR = 32,
    parameter int WC_W   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_ev,
    input logic            stop_ev,
    input logic            byte_vld,
    input logic            rd_req,
    input logic            ack_vld,
    input logic            ack,
    input logic            rd_vld,
    input logic            busy,
    input logic            in_cmd,
    input logic            pwd_last,
    input logic            sess,
    input logic [WC_W-1:0] wcnt
);
    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(byte_vld)); // R12

    AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(rd_req)); // R6

    AST_PWD_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwd_last && byte_vld && !start_ev && !stop_ev) |=> busy); // R2

    AST_BUSY_CMD_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_cmd && byte_vld && !start_ev && !stop_ev) |=> (ack_vld && !ack)); // R10

    AST_BUSY_STOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop_ev && !start_ev && sess) |=> sess); // R10

    AST_SECTOR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= WC_W'(SECTOR)); // R5
endmodule

bind pwgate_seq pwgate_chk #(.SECTOR(SECTOR), .WC_W(WC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .byte_vld(byte_vld),
    .rd_req  (rd_req),
    .ack_vld (ack_vld),
    .ack     (ack),
    .rd_vld  (rd_vld),
    .busy    (busy_w),
    .in_cmd  (chk_in_cmd),
    .pwd_last(chk_pwd_last),
    .sess    (chk_sess),
    .wcnt    (chk_wcnt)
);

// File: tb/sim_pwgate_seq.sv
module sim_pwgate_seq;
    localparam int BUSY = 20;
    localparam logic [63:0] PW_A = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] PW_B = 64'h0123_4567_89AB_CDEE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_ev = 1'b0;
    logic       stop_ev = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       rd_req = 1'b0;
    logic       ack_vld;
    logic       ack;
    logic       rd_vld;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    pwgate_seq #(.BUSY_CYC(BUSY)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_ev(start_ev),
        .stop_ev (stop_ev),
        .byte_vld(byte_vld),
        .byte_in (byte_in),
        .rd_req  (rd_req),
        .ack_vld (ack_vld),
        .ack     (ack),
        .rd_vld  (rd_vld),
        .rd_data (rd_data)
    );

    int    total = 0;
    int    bad = 0;
    bit    fin = 0;
    bit    ack_exp_q[$];
    string ack_tag_q[$];
    logic [7:0] rd_exp_q[$];
    string rd_tag_q[$];

    function automatic void chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endfunction

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            if (ack_vld) begin
                if (ack_exp_q.size() == 0) begin
                    chk(0, "R12", "unexpected ack pulse", int'(ack), 0);
                end else begin
                    bit    e;
                    string t;
                    e = ack_exp_q.pop_front();
                    t = ack_tag_q.pop_front();
                    chk(ack == e, t, "ack", int'(ack), int'(e));
                end
            end
            if (rd_vld) begin
                if (rd_exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected read byte", int'(rd_data), 0);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = rd_exp_q.pop_front();
                    t = rd_tag_q.pop_front();
                    chk(rd_data === e, t, "read data", int'(rd_data), int'(e));
                end
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_c();
        @(negedge clk); start_ev = 1'b1;
        @(negedge clk); start_ev = 1'b0;
    endtask

    task automatic stop_c();
        @(negedge clk); stop_ev = 1'b1;
        @(negedge clk); stop_ev = 1'b0;
    endtask

    task automatic send(logic [7:0] b, bit e, string t);
        ack_exp_q.push_back(e);
        ack_tag_q.push_back(t);
        @(negedge clk); byte_in = b; byte_vld = 1'b1;
        @(negedge clk); byte_vld = 1'b0;
    endtask

    task automatic rd(logic [7:0] e, string t);
        rd_exp_q.push_back(e);
        rd_tag_q.push_back(t);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic poll(bit e, string t);
        start_c();
        send(8'hF0, e, t);
    endtask

    task automatic send_pw(logic [63:0] p, string t);
        for (int i = 0; i < 8; i++) begin
            send(p[63-8*i -: 8], 1'b1, t);
        end
    endtask

    task automatic open(logic [7:0] c, logic [63:0] p, bit good, string t);
        start_c();
        send(c, 1'b1, "R1");
        send_pw(p, "R2");
        poll(1'b0, "R2 busy poll");
        cyc(BUSY + 5);
        poll(good, t);
    endtask

    task automatic addr(logic [15:0] a);
        send(a[15:8], 1'b1, "R4");
        send(a[7:0], 1'b1, "R4");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack_vld == 1'b0 && rd_vld == 1'b0, "R12", "reset outputs",
            int'({ack_vld, rd_vld}), 0);
        send(8'h80, 1'b0, "R12 byte before start");

        // R1: illegal command, then standby
        start_c();
        send(8'h55, 1'b0, "R1 illegal code");
        send(8'h80, 1'b0, "R1 standby after illegal");

        // sector write to array 0 across its top, with R10 busy checks
        start_c();
        send(8'hA0, 1'b1, "R1");
        send_pw(64'h0, "R2");
        poll(1'b0, "R2 busy poll");
        start_c();
        send(8'h80, 1'b0, "R10 command while busy");
        stop_c();
        cyc(BUSY + 5);
        poll(1'b1, "R3 good password, R10 session kept");
        addr(16'h07FE);
        send(8'h11, 1'b1, "R5");
        send(8'h22, 1'b1, "R5");
        send(8'h33, 1'b1, "R5");
        stop_c();
        poll(1'b0, "R5 busy after write stop");
        cyc(BUSY + 5);

        // read array 0: R4 order, R7 random, R6 wrap
        open(8'h80, 64'h0, 1'b1, "R3");
        addr(16'h07FE);
        rd(8'h11, "R4 high byte first");
        start_c();
        send(8'hFE, 1'b1, "R7");
        rd(8'h11, "R7 high bits kept");
        rd(8'h22, "R6");
        rd(8'h33, "R6 wrap array 0");
        stop_c();

        // full sector to array 1, 33rd byte refused
        open(8'hB0, 64'h0, 1'b1, "R3");
        addr(16'h0000);
        for (int i = 0; i < 32; i++) begin
            send(8'h40 + 8'(i), 1'b1, "R5");
        end
        send(8'hEE, 1'b0, "R5 byte beyond sector");
        stop_c();
        cyc(BUSY + 5);
        open(8'h90, 64'h0, 1'b1, "R3");
        addr(16'h001E);
        rd(8'h5E, "R6");
        rd(8'h5F, "R6");
        rd(8'h40, "R6 wrap array 1 / R5 not stored");
        start_c();
        send(8'h05, 1'b1, "R7");
        rd(8'h45, "R7 array 1 full address");
        stop_c();

        // R3 wrong password
        open(8'h80, 64'h1, 1'b0, "R3 wrong password");
        send(8'h07, 1'b0, "R3 session ended");

        // R8 mismatched copies
        open(8'h88, 64'h0, 1'b1, "R3");
        send(8'h00, 1'b1, "R8");
        send(8'h00, 1'b1, "R8");
        send_pw(PW_A, "R8");
        send_pw(PW_B, "R8");
        poll(1'b1, "R8 mismatch immediate ack");
        open(8'h80, 64'h0, 1'b1, "R8 old value kept");
        stop_c();

        // R8 matching copies
        open(8'h88, 64'h0, 1'b1, "R3");
        send(8'h00, 1'b1, "R8");
        send(8'h00, 1'b1, "R8");
        send_pw(PW_A, "R8");
        send_pw(PW_A, "R8");
        poll(1'b0, "R8 match busy");
        cyc(BUSY + 5);
        poll(1'b1, "R8 busy over");
        open(8'h80, 64'h0, 1'b0, "R8 old value rejected");
        open(8'h80, PW_A, 1'b1, "R8 new value accepted");
        addr(16'h07FE);
        rd(8'h11, "R8");
        stop_c();

        // R9 reset password command
        open(8'hE0, 64'h0, 1'b1, "R9");
        cyc(BUSY + 5);
        open(8'h80, 64'h0, 1'b1, "R9 slots zero");
        stop_c();

        // R11 aborts
        start_c();
        send(8'hA0, 1'b1, "R1");
        send(8'h00, 1'b1, "R2");
        send(8'h00, 1'b1, "R2");
        stop_c();
        send(8'h00, 1'b0, "R11 stop during password");
        open(8'h80, 64'h0, 1'b1, "R3");
        send(8'h07, 1'b1, "R4");
        stop_c();
        poll(1'b1, "R11 poll without session");
        send(8'hFE, 1'b0, "R11 address abandoned");

        cyc(5);
        chk(ack_exp_q.size() == 0 && rd_exp_q.size() == 0, "R12",
            "missing outputs", ack_exp_q.size() + rd_exp_q.size(), 0);
        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule